// File: doc/BRIEF.md
# Serial Wiper Step Controller

This block runs the fine-tuning mode of a multi-channel digital potentiometer controller. A serial-bus front end decodes the instruction byte and acknowledges it. If that byte asks for stepping, the block arms itself for the channel named in the byte. From then on, each clock pulse on the bus moves that channel's 6-bit wiper code by one position. No bytes are framed and no acknowledge bits are sent during this mode. The level of the data line at the start of each pulse chooses the direction.

The block takes the already synchronized clock and data levels of the bus, one-cycle strobes from the front end for START, STOP and the acknowledged instruction byte, and the present code of every wiper register. It drives a one-cycle step request per channel plus a shared direction bit. The wiper registers apply these requests, so stepping only touches volatile state and never starts a programming cycle.

A direction is sampled when the bus clock rises. The step itself is released when the bus clock falls. A pulse that ends in a START or STOP (the bus clock is high while the data line moves) therefore produces no step.

Top module: `wiper_step_ctrl`

## Requirements
- R1: The mode is entered only when `instr_ack` strobes with `instr_byte[7:4]` = 4'b0010 and `instr_byte[1:0]` = 2'b00. The selected channel is `instr_byte[3:2]`. Any other acknowledged byte leaves the block idle, and later pulses change no wiper.
- R2: In the mode, a bus clock pulse with `sda_s` = 1 at its rising edge raises the selected wiper code by exactly one.
- R3: In the mode, a bus clock pulse with `sda_s` = 0 at its rising edge lowers the selected wiper code by exactly one.
- R4: Exactly one step is issued per bus clock pulse, however long the clock stays high. The step request is asserted for a single cycle, in the cycle after the falling edge is seen.
- R5: Steps saturate. No up request is issued while the selected code is 63, and no down request is issued while it is 0.
- R6: A `start_seen` or `stop_seen` strobe ends the mode. Later pulses change no wiper until the mode is entered again.
- R7: A pulse during which `start_seen` or `stop_seen` strobes issues no step.
- R8: Only the selected channel receives requests. At most one bit of `step_req` is high in any cycle.
- R9: After reset the block is idle with `step_req` all zero.
- R10: Bus clock pulses before any stepping command issue no step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_s | input | 1 | Synchronized bus clock level |
| sda_s | input | 1 | Synchronized bus data level |
| start_seen | input | 1 | One-cycle strobe for a START or repeated START |
| stop_seen | input | 1 | One-cycle strobe for a STOP |
| instr_ack | input | 1 | One-cycle strobe when the instruction byte has been acknowledged |
| instr_byte | input | 8 | Instruction byte: opcode [7:4], channel [3:2], register field [1:0] |
| wiper_codes | input | NCH*CODE_W | Present wiper codes, channel i at bits [i*CODE_W +: CODE_W] |
| step_req | output | NCH | One-cycle step request per channel |
| step_up | output | 1 | Direction for `step_req`: 1 raises the code, 0 lowers it |

## Verification
The bench builds the block with its defaults: four channels and 6-bit codes. This makes all four channel encodings of the instruction byte reachable, and both saturation bounds (0 and 63) can be hit within a few pulses. Random frames start wipers near the bounds and push long runs in one direction, so clamping happens often. Directed frames cover rejected opcodes, held-high clock pulses, and pulses cut short by START or STOP.

// File: rtl/wstep_pkg.sv
package wstep_pkg;
  // Opcode nibble that arms stepping mode
  localparam logic [3:0] OPC_STEP = 4'b0010;
  // Width of the channel field inside the instruction byte
  localparam int SEL_W = 2;
  localparam int INSTR_W = 8;

  typedef logic [INSTR_W-1:0] instr_t;

  typedef enum logic {
    MODE_IDLE = 1'b0,
    MODE_STEP = 1'b1
  } mode_e;

  function automatic logic [3:0] instr_opc(input instr_t b);
    return b[7:4];
  endfunction

  function automatic logic [SEL_W-1:0] instr_sel(input instr_t b);
    return b[3:2];
  endfunction

  function automatic logic [1:0] instr_reg(input instr_t b);
    return b[1:0];
  endfunction
endpackage

// File: rtl/wstep_decode.sv
module wstep_decode
  import wstep_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_seen,
  input  logic             stop_seen,
  input  logic             instr_ack,
  input  instr_t           instr_byte,
  output logic             mode_on,
  output logic [SEL_W-1:0] sel
);
  mode_e            mode_q, mode_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             bus_cond;
  logic             hit;

  assign bus_cond = start_seen | stop_seen;
  assign hit = (instr_opc(instr_byte) == OPC_STEP) &&
               (instr_reg(instr_byte) == 2'b00) &&
               ({30'd0, instr_sel(instr_byte)} < NCH);

  // next-state logic
  always_comb begin
    mode_d = mode_q;
    sel_d  = sel_q;
    if (bus_cond) begin
      mode_d = MODE_IDLE;
    end else if (instr_ack) begin
      if (hit) begin
        mode_d = MODE_STEP;
        sel_d  = instr_sel(instr_byte);
      end else begin
        mode_d = MODE_IDLE;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_IDLE;
      sel_q  <= '0;
    end else begin
      mode_q <= mode_d;
      sel_q  <= sel_d;
    end
  end

  assign mode_on = (mode_q == MODE_STEP);
  assign sel     = sel_q;

  // R6: a bus condition always leaves the mode
  p_exit_on_cond_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cond |=> !mode_on);
  // R1: a matching acknowledged byte arms the block
  p_enter_on_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_ack && hit && !bus_cond) |=> mode_on);
  // R1: a non-matching acknowledged byte leaves the block idle
  p_reject_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_ack && !hit && !bus_cond) |=> !mode_on);
  // R1: the channel only changes through an acknowledged byte
  p_sel_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_ack |=> $stable(sel));
endmodule

// File: rtl/wstep_pulse.sv
module wstep_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  input  logic bus_cond,
  input  logic mode_on,
  output logic commit,
  output logic commit_up
);
  logic scl_q;
  logic pend_q, pend_d;
  logic dir_q, dir_d;
  logic rise, fall;

  assign rise = scl_s & ~scl_q;
  assign fall = ~scl_s & scl_q;

  // next-state: capture direction at rise, release at fall
  always_comb begin
    pend_d = pend_q;
    dir_d  = dir_q;
    if (bus_cond || !mode_on) begin
      pend_d = 1'b0;
    end else if (rise) begin
      pend_d = 1'b1;
      dir_d  = sda_s;
    end else if (fall) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      pend_q <= 1'b0;
      dir_q  <= 1'b0;
    end else begin
      scl_q  <= scl_s;
      pend_q <= pend_d;
      if (rise) begin
        dir_q <= dir_d;
      end
    end
  end

  assign commit    = fall & pend_q & mode_on & ~bus_cond;
  assign commit_up = dir_q;

  // R4: a commit never repeats in the next cycle
  p_single_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
  // R7: a START or STOP cancels any pending step
  p_cond_cancels_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cond |=> !pend_q);
  // R4: the captured direction holds until the next rise
  p_dir_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(dir_q));
endmodule

// File: rtl/wstep_stepgen.sv
module wstep_stepgen
  import wstep_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CODE_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_on,
  input  logic                  commit,
  input  logic                  commit_up,
  input  logic [SEL_W-1:0]      sel,
  input  logic [NCH*CODE_W-1:0] wiper_codes,
  output logic [NCH-1:0]        step_req,
  output logic                  step_up
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_MIN = '0;

  logic [NCH-1:0] req_d, req_q;
  logic           up_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [CODE_W-1:0] code;
    logic              room;
    assign code = wiper_codes[g*CODE_W +: CODE_W];
    assign room = commit_up ? (code != CODE_MAX) : (code != CODE_MIN);
    assign req_d[g] = commit && (sel == SEL_W'(g)) && room;

    // R5: never request past either end of the code range
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q[g] && up_q) |-> (code != CODE_MAX));
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q[g] && !up_q) |-> (code != CODE_MIN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      up_q  <= 1'b0;
    end else begin
      req_q <= req_d;
      if (commit) begin
        up_q <= commit_up;
      end
    end
  end

  assign step_req = req_q;
  assign step_up  = up_q;

  // R8: at most one channel steps per cycle
  p_onehot_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(step_req));
  // R4: each request lasts a single cycle
  p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req != '0) |=> (step_req == '0));
  // R10: requests only follow a cycle spent in the mode
  p_req_needs_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req != '0) |-> $past(mode_on));
endmodule

// File: rtl/wiper_step_ctrl.sv
module wiper_step_ctrl
  import wstep_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CODE_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_s,
  input  logic                  sda_s,
  input  logic                  start_seen,
  input  logic                  stop_seen,
  input  logic                  instr_ack,
  input  logic [7:0]            instr_byte,
  input  logic [NCH*CODE_W-1:0] wiper_codes,
  output logic [NCH-1:0]        step_req,
  output logic                  step_up
);
  logic             mode_on;
  logic [SEL_W-1:0] sel;
  logic             commit;
  logic             commit_up;
  logic             bus_cond;

  assign bus_cond = start_seen | stop_seen;

  wstep_decode #(.NCH(NCH)) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_seen (start_seen),
    .stop_seen  (stop_seen),
    .instr_ack  (instr_ack),
    .instr_byte (instr_byte),
    .mode_on    (mode_on),
    .sel        (sel)
  );

  wstep_pulse u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .bus_cond  (bus_cond),
    .mode_on   (mode_on),
    .commit    (commit),
    .commit_up (commit_up)
  );

  wstep_stepgen #(.NCH(NCH), .CODE_W(CODE_W)) u_stepgen (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_on     (mode_on),
    .commit      (commit),
    .commit_up   (commit_up),
    .sel         (sel),
    .wiper_codes (wiper_codes),
    .step_req    (step_req),
    .step_up     (step_up)
  );

  // R9: outputs stay quiet in the cycle after reset release
  p_quiet_after_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (step_req == '0));
endmodule

// File: tb/wiper_step_ctrl_tb.sv
`timescale 1ns/1ps
module wiper_step_ctrl_tb_top;
  localparam int NCH = 4;
  localparam int CW  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic start_det = 1'b0, stop_det = 1'b0, cmd_ack = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic [NCH*CW-1:0] codes;
  logic [NCH-1:0] step_req;
  logic step_up;

  logic [CW-1:0] wreg [NCH];
  logic [CW-1:0] expw [NCH];
  logic ld_en = 1'b0;
  int   ld_i = 0;
  logic [CW-1:0] ld_v = '0;
  bit   exp_act = 0;
  int   exp_ch = 0;
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  always #2 clk = ~clk;

  wiper_step_ctrl #(.NCH(NCH), .CODE_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_s(scl), .sda_s(sda),
    .start_seen(start_det), .stop_seen(stop_det),
    .instr_ack(cmd_ack), .instr_byte(cmd_byte),
    .wiper_codes(codes), .step_req(step_req), .step_up(step_up)
  );

  // external wiper registers applying the requests
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) wreg[i] <= '0;
    end else if (ld_en) begin
      wreg[ld_i] <= ld_v;
    end else begin
      for (int i = 0; i < NCH; i++)
        if (step_req[i]) wreg[i] <= step_up ? wreg[i] + 1'b1 : wreg[i] - 1'b1;
    end
  end

  always_comb for (int i = 0; i < NCH; i++) codes[i*CW +: CW] = wreg[i];

  function automatic logic [CW-1:0] sat_step(logic [CW-1:0] c, bit up);
    if (up) return (c == 6'd63) ? c : c + 6'd1;
    return (c == 6'd0) ? c : c - 6'd1;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic check_all(string req);
    for (int i = 0; i < NCH; i++) chk(wreg[i] == expw[i], req, wreg[i], expw[i]);
  endtask

  task automatic set_w(int i, logic [CW-1:0] v);
    ld_en = 1'b1; ld_i = i; ld_v = v;
    tick(1);
    ld_en = 1'b0;
    expw[i] = v;
  endtask

  task automatic send_cmd(logic [7:0] b);
    cmd_byte = b; cmd_ack = 1'b1;
    tick(1);
    cmd_ack = 1'b0;
    tick(2);
    if (b[7:4] == 4'b0010 && b[1:0] == 2'b00) begin
      exp_act = 1; exp_ch = int'(b[3:2]);
    end else exp_act = 0;
  endtask

  task automatic pulse(bit d, int high = 3);
    scl = 1'b0; tick(1);
    sda = d; tick(2);
    scl = 1'b1; tick(high);
    scl = 1'b0; tick(3);
    if (exp_act) expw[exp_ch] = sat_step(expw[exp_ch], d);
  endtask

  // START while a pulse with data high is in flight
  task automatic start_cond();
    scl = 1'b0; tick(1);
    sda = 1'b1; tick(2);
    scl = 1'b1; tick(2);
    sda = 1'b0; start_det = 1'b1; tick(1);
    start_det = 1'b0; tick(2);
    scl = 1'b0; tick(3);
    exp_act = 0;
  endtask

  // STOP: clock rises with data low, then data rises
  task automatic stop_cond();
    scl = 1'b0; tick(1);
    sda = 1'b0; tick(2);
    scl = 1'b1; tick(2);
    sda = 1'b1; stop_det = 1'b1; tick(1);
    stop_det = 1'b0; tick(3);
    exp_act = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED);
    for (int i = 0; i < NCH; i++) expw[i] = '0;
    tick(4);
    rst_n = 1'b1;
    tick(2);
    // R9: idle after reset
    chk(step_req == '0, "R9 step_req after reset", int'(step_req), 0);
    check_all("R9 wipers after reset");

    // R10: pulses before any command
    start_cond();
    for (int k = 0; k < 3; k++) pulse(1);
    check_all("R10 pulses without command");

    // R2 / R3 on channel 1
    set_w(1, 6'd10);
    start_cond(); send_cmd(8'h24);
    for (int k = 0; k < 5; k++) pulse(1);
    chk(wreg[1] == 6'd15, "R2 five up steps", wreg[1], 15);
    for (int k = 0; k < 7; k++) pulse(0);
    chk(wreg[1] == 6'd8, "R3 seven down steps", wreg[1], 8);
    stop_cond();
    // R7: the clock pulse carrying the STOP did not step down
    chk(wreg[1] == 6'd8, "R7 no step on STOP pulse", wreg[1], 8);
    // R6: pulses after STOP are ignored
    for (int k = 0; k < 2; k++) pulse(1);
    chk(wreg[1] == 6'd8, "R6 pulses after STOP", wreg[1], 8);
    check_all("R8 other channels untouched");

    // R5: saturation at both ends
    set_w(2, 6'd62);
    start_cond(); send_cmd(8'h28);
    for (int k = 0; k < 4; k++) pulse(1);
    stop_cond();
    chk(wreg[2] == 6'd63, "R5 clamp at 63", wreg[2], 63);
    set_w(0, 6'd1);
    start_cond(); send_cmd(8'h20);
    for (int k = 0; k < 3; k++) pulse(0);
    stop_cond();
    chk(wreg[0] == 6'd0, "R5 clamp at 0", wreg[0], 0);

    // R4: a long high phase gives one step
    set_w(3, 6'd30);
    start_cond(); send_cmd(8'h2C);
    pulse(1, 20);
    chk(wreg[3] == 6'd31, "R4 one step per long pulse", wreg[3], 31);
    stop_cond();

    // R1: rejected bytes
    start_cond(); send_cmd(8'h25);
    for (int k = 0; k < 3; k++) pulse(1);
    stop_cond();
    chk(wreg[1] == 6'd8, "R1 register field nonzero", wreg[1], 8);
    start_cond(); send_cmd(8'hA4);
    for (int k = 0; k < 3; k++) pulse(0);
    stop_cond();
    chk(wreg[1] == 6'd8, "R1 other opcode", wreg[1], 8);

    // R6 / R7: repeated START ends the mode
    start_cond(); send_cmd(8'h24);
    pulse(1);
    start_cond();
    for (int k = 0; k < 3; k++) pulse(1);
    stop_cond();
    chk(wreg[1] == 6'd9, "R6 repeated START ends mode", wreg[1], 9);
    check_all("R7 START pulse gives no step");

    // random frames
    for (int f = 0; f < 40; f++) begin
      int ch, np, bias;
      logic [7:0] b;
      ch = int'($urandom_range(0, NCH - 1));
      if ($urandom_range(0, 3) == 0) set_w(ch, 6'($urandom_range(0, 63)));
      b = {4'b0010, 2'(ch), 2'b00};
      if ($urandom_range(0, 9) == 0) b[7:4] = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 9) == 0) b[1:0] = 2'($urandom_range(0, 3));
      start_cond(); send_cmd(b);
      np = int'($urandom_range(0, 80));
      bias = int'($urandom_range(0, 2));
      for (int k = 0; k < np; k++) begin
        bit d;
        if (bias == 0) d = ($urandom_range(0, 9) < 8);
        else if (bias == 1) d = ($urandom_range(0, 9) < 2);
        else d = $urandom_range(0, 1) == 1;
        pulse(d);
      end
      if ($urandom_range(0, 1) == 0) stop_cond(); else start_cond();
      check_all("R2 R3 R5 random frame");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule